// File: doc/BRIEF.md
# Multi-Page-Size Translation Buffer

This block is a fully associative address translation buffer of 128 entries that eight hardware strands share. Each entry carries its own page size, chosen from five values between 8 KB and 2 GB, together with the strand that owns it, the virtual page and the physical page. A lookup presents a virtual address and a strand number. One cycle later the block reports whether the translation hit and, on a hit, the physical address. That address is built from the entry's physical page bits above its page boundary and the lookup's own address bits below it.

When a lookup misses, the block raises a request to an external table walker and holds it until the walker takes it. The walker later writes the translation back through a refill port. A refill goes into the lowest-numbered empty entry. When no entry is empty, a round-robin pointer chooses the entry to replace. Software-style maintenance is limited to two controls: clear every entry, or clear every entry owned by one strand, each in a single cycle.

The lookup port is valid/ready. A lookup is taken on a clock edge where `lk_valid` and `lk_ready` are both high. `lk_ready` is low while a walk request is outstanding. The walk request port is valid/ready as well: `walk_req_valid` stays high with its address and strand unchanged until a cycle in which `walk_req_ready` is high. The result and the refill and invalidate controls have no back-pressure. A result pulse cannot be stalled, and a refill is taken in the cycle it is presented.

Top module: `tlb_multi_page`

## Requirements
- R1: A lookup taken at a clock edge produces `res_valid` high for exactly one cycle, starting right after that edge. No other cycle has `res_valid` high.
- R2: The page size code is 0 = 8 KB, 1 = 64 KB, 2 = 4 MB, 3 = 256 MB and 4 = 2 GB. Codes 5 to 7 behave as 8 KB. An entry matches when the virtual address bits at and above its page boundary equal the stored virtual page. On a hit, `res_pa` holds the stored physical page bits above the boundary and the lookup address bits below it. On a miss, `res_pa` is zero.
- R3: A hit also requires the entry's strand number to equal the lookup's strand number. The same page looked up under another strand misses.
- R4: A miss raises `walk_req_valid` in the same cycle as the miss result, carrying the missed address and strand. Both stay unchanged until `walk_req_ready` is high at a clock edge. While the request is pending, `lk_ready` is low and `lk_valid` has no effect.
- R5: A refill writes the lowest-numbered empty entry. When all entries are valid, the victim comes from a pointer that is 0 after reset and advances by one for each such replacement, wrapping after the last entry.
- R6: When several entries match, the result uses the lowest-numbered one and `res_multi` is high along with `res_hit`.
- R7: `inv_all` empties every entry in one cycle. `inv_strand_en` empties every entry owned by `inv_strand` in one cycle and leaves other strands' entries in place.
- R8: A refill presented in the same cycle as either invalidate is dropped.
- R9: After reset the buffer is empty, `res_valid` and `walk_req_valid` are low, and `lk_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup can be taken (no walk pending) |
| lk_va | input | 48 | Lookup virtual address |
| lk_strand | input | 3 | Lookup strand number |
| res_valid | output | 1 | Result valid, one cycle after the lookup is taken |
| res_hit | output | 1 | Translation found |
| res_multi | output | 1 | More than one entry matched |
| res_pa | output | 40 | Translated physical address (zero on a miss) |
| walk_req_valid | output | 1 | Walk request pending |
| walk_req_ready | input | 1 | Walker accepts the request |
| walk_req_va | output | 48 | Missed virtual address |
| walk_req_strand | output | 3 | Missed strand number |
| rf_valid | input | 1 | Refill write |
| rf_vpn | input | 35 | Refill virtual page (address bits 47..13) |
| rf_ppn | input | 27 | Refill physical page (address bits 39..13) |
| rf_size | input | 3 | Refill page size code |
| rf_strand | input | 3 | Refill owner strand |
| inv_all | input | 1 | Clear every entry |
| inv_strand_en | input | 1 | Clear entries of one strand |
| inv_strand | input | 3 | Strand to clear |

## Verification
The bench probes each page size exactly at its boundary: the last in-page address must hit and the first address past the page must miss. It also uses a physical page whose low bits are non-zero, so a design that masked the wrong bits would let stray physical bits into `res_pa` or fail to translate across a large page. It builds two overlapping entries to expose a wrong multi-hit winner. It fills all 128 entries and then frees a single slot, which separates first-empty placement from round-robin placement; a design that mixed the two would evict the wrong page. It holds the walker stalled while offering further lookups, and it issues refills together with invalidates, so a design that took a lookup during a pending walk, or kept a refill that should have been dropped, produces an extra result or an extra hit.

// File: rtl/tlb_mps_pkg.sv
package tlb_mps_pkg;

  localparam int unsigned PAGE_BASE_SHIFT = 13;

  typedef enum logic [2:0] {
    SZ_8K   = 3'd0,
    SZ_64K  = 3'd1,
    SZ_4M   = 3'd2,
    SZ_256M = 3'd3,
    SZ_2G   = 3'd4
  } page_size_e;

  // number of page-number bits (above the 8 KB base) that are page offset
  function automatic int unsigned size_extra_bits(input logic [2:0] code);
    case (page_size_e'(code))
      SZ_64K:  return 3;
      SZ_4M:   return 9;
      SZ_256M: return 15;
      SZ_2G:   return 18;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/tlb_mps_array.sv
module tlb_mps_array #(
  parameter int unsigned N     = 128,
  parameter int unsigned VT_W  = 35,
  parameter int unsigned PT_W  = 27,
  parameter int unsigned SID_W = 3,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [VT_W-1:0]  wr_vpn,
  input  logic [PT_W-1:0]  wr_ppn,
  input  logic [2:0]       wr_size,
  input  logic [SID_W-1:0] wr_strand,
  input  logic             inv_all,
  input  logic             inv_strand_en,
  input  logic [SID_W-1:0] inv_strand,
  input  logic [VT_W-1:0]  cmp_vpn,
  input  logic [SID_W-1:0] cmp_strand,
  output logic [N-1:0]     match_vec,
  output logic [N-1:0]     valid_vec,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [PT_W-1:0]  rd_ppn,
  output logic [PT_W-1:0]  rd_keep
);

  logic [N-1:0]     v_q;
  logic [VT_W-1:0]  vpn_q  [N];
  logic [PT_W-1:0]  ppn_q  [N];
  logic [2:0]       size_q [N];
  logic [SID_W-1:0] sid_q  [N];

  // ones on the page-number bits that take part in the compare
  function automatic logic [VT_W-1:0] keep_mask(input logic [2:0] code);
    logic [VT_W-1:0] m;
    m = {VT_W{1'b1}} << tlb_mps_pkg::size_extra_bits(code);
    return m;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
    end else begin
      if (wr_en) v_q[wr_idx] <= 1'b1;
      if (inv_all) begin
        v_q <= '0;
      end else if (inv_strand_en) begin
        for (int i = 0; i < int'(N); i++) begin
          if (sid_q[i] == inv_strand) v_q[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpn_q[wr_idx]  <= wr_vpn;
      ppn_q[wr_idx]  <= wr_ppn;
      size_q[wr_idx] <= wr_size;
      sid_q[wr_idx]  <= wr_strand;
    end
  end

  for (genvar g = 0; g < int'(N); g++) begin : g_cmp
    logic [VT_W-1:0] keep;
    assign keep = keep_mask(size_q[g]);
    assign match_vec[g] = v_q[g] && (sid_q[g] == cmp_strand) &&
                          (((vpn_q[g] ^ cmp_vpn) & keep) == '0);
  end

  assign valid_vec = v_q;
  assign rd_ppn    = ppn_q[rd_idx];
  assign rd_keep   = PT_W'(keep_mask(size_q[rd_idx]));

  AST_INV_ALL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid_vec == '0)); // R7

  AST_REFILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !inv_all && !inv_strand_en) |=> valid_vec[$past(wr_idx)]); // R5

endmodule

// File: rtl/tlb_mps_pick.sv
module tlb_mps_pick #(
  parameter int unsigned N     = 128,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  output logic [IDX_W-1:0] idx,
  output logic             any,
  output logic             multi
);

  always_comb begin
    idx = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign any   = |req;
  assign multi = |(req & (req - N'(1)));

  AST_MULTI_TWO_PLUS: assert property (@(posedge clk) disable iff (!rst_n)
    multi |-> ($countones(req) > 1)); // R6

  AST_PICK_IS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> req[idx]); // R6

endmodule

// File: rtl/tlb_mps_victim.sv
module tlb_mps_victim #(
  parameter int unsigned N     = 128,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid_vec,
  input  logic             fire,
  output logic [IDX_W-1:0] vict_idx
);

  logic [IDX_W-1:0] rr_q;
  logic [IDX_W-1:0] free_idx;
  logic             free_any;

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  assign vict_idx = free_any ? free_idx : rr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_q <= '0;
    end else if (fire && !free_any) begin
      rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + IDX_W'(1);
    end
  end

  AST_VICTIM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && free_any) |-> !valid_vec[vict_idx]); // R5

  AST_RR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(rr_q)); // R5

endmodule

// File: rtl/tlb_multi_page.sv
module tlb_multi_page #(
  parameter int unsigned VA_W    = 48,
  parameter int unsigned PA_W    = 40,
  parameter int unsigned ENTRIES = 128,
  parameter int unsigned SID_W   = 3
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       lk_valid,
  output logic                                       lk_ready,
  input  logic [VA_W-1:0]                            lk_va,
  input  logic [SID_W-1:0]                           lk_strand,
  output logic                                       res_valid,
  output logic                                       res_hit,
  output logic                                       res_multi,
  output logic [PA_W-1:0]                            res_pa,
  output logic                                       walk_req_valid,
  input  logic                                       walk_req_ready,
  output logic [VA_W-1:0]                            walk_req_va,
  output logic [SID_W-1:0]                           walk_req_strand,
  input  logic                                       rf_valid,
  input  logic [VA_W-tlb_mps_pkg::PAGE_BASE_SHIFT-1:0] rf_vpn,
  input  logic [PA_W-tlb_mps_pkg::PAGE_BASE_SHIFT-1:0] rf_ppn,
  input  logic [2:0]                                 rf_size,
  input  logic [SID_W-1:0]                           rf_strand,
  input  logic                                       inv_all,
  input  logic                                       inv_strand_en,
  input  logic [SID_W-1:0]                           inv_strand
);

  localparam int unsigned OFS   = tlb_mps_pkg::PAGE_BASE_SHIFT;
  localparam int unsigned VT_W  = VA_W - OFS;
  localparam int unsigned PT_W  = PA_W - OFS;
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  logic               accept;
  logic               walk_pend_q;
  logic [ENTRIES-1:0] match_vec;
  logic [ENTRIES-1:0] valid_vec;
  logic [IDX_W-1:0]   hit_idx;
  logic               any_hit;
  logic               multi_hit;
  logic [IDX_W-1:0]   vict_idx;
  logic               wr_go;
  logic [PT_W-1:0]    rd_ppn;
  logic [PT_W-1:0]    rd_keep;
  logic [PT_W-1:0]    pa_page;

  assign lk_ready = !walk_pend_q;
  assign accept   = lk_valid && lk_ready;
  assign wr_go    = rf_valid && !(inv_all || inv_strand_en);

  tlb_mps_array #(
    .N(ENTRIES), .VT_W(VT_W), .PT_W(PT_W), .SID_W(SID_W), .IDX_W(IDX_W)
  ) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_go), .wr_idx(vict_idx), .wr_vpn(rf_vpn), .wr_ppn(rf_ppn),
    .wr_size(rf_size), .wr_strand(rf_strand),
    .inv_all(inv_all), .inv_strand_en(inv_strand_en), .inv_strand(inv_strand),
    .cmp_vpn(lk_va[VA_W-1:OFS]), .cmp_strand(lk_strand),
    .match_vec(match_vec), .valid_vec(valid_vec),
    .rd_idx(hit_idx), .rd_ppn(rd_ppn), .rd_keep(rd_keep)
  );

  tlb_mps_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick (
    .clk(clk), .rst_n(rst_n), .req(match_vec),
    .idx(hit_idx), .any(any_hit), .multi(multi_hit)
  );

  tlb_mps_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec),
    .fire(wr_go), .vict_idx(vict_idx)
  );

  // page bits above the boundary from the entry, below it from the address
  assign pa_page = (rd_ppn & rd_keep) | (lk_va[OFS+PT_W-1:OFS] & ~rd_keep);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_multi <= 1'b0;
      res_pa    <= '0;
    end else begin
      res_valid <= accept;
      res_hit   <= accept && any_hit;
      res_multi <= accept && multi_hit;
      res_pa    <= (accept && any_hit) ? {pa_page, lk_va[OFS-1:0]} : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      walk_pend_q     <= 1'b0;
      walk_req_va     <= '0;
      walk_req_strand <= '0;
    end else begin
      if (walk_pend_q && walk_req_ready) walk_pend_q <= 1'b0;
      if (accept && !any_hit) begin
        walk_pend_q     <= 1'b1;
        walk_req_va     <= lk_va;
        walk_req_strand <= lk_strand;
      end
    end
  end

  assign walk_req_valid = walk_pend_q;

  AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_valid && !walk_req_ready) |=>
      (walk_req_valid && $stable(walk_req_va) && $stable(walk_req_strand))); // R4

  AST_MISS_OPENS_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> walk_req_valid); // R4

  AST_HIT_KEEPS_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> (res_pa[OFS-1:0] == $past(lk_va[OFS-1:0]))); // R2

  AST_MULTI_IMPLIES_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    res_multi |-> res_hit); // R6

endmodule

// File: tb/tlb_multi_page_tb_top.sv
`timescale 1ns/1ps
module tlb_multi_page_tb_top;

  localparam int NE = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [47:0] lk_va = '0;
  logic [2:0]  lk_strand = '0;
  logic        res_valid, res_hit, res_multi;
  logic [39:0] res_pa;
  logic        walk_req_valid;
  logic        walk_req_ready = 1'b1;
  logic [47:0] walk_req_va;
  logic [2:0]  walk_req_strand;
  logic        rf_valid = 1'b0;
  logic [34:0] rf_vpn = '0;
  logic [26:0] rf_ppn = '0;
  logic [2:0]  rf_size = '0;
  logic [2:0]  rf_strand = '0;
  logic        inv_all = 1'b0;
  logic        inv_strand_en = 1'b0;
  logic [2:0]  inv_strand = '0;

  always #2 clk = ~clk;

  tlb_multi_page dut_i (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_va(lk_va), .lk_strand(lk_strand),
    .res_valid(res_valid), .res_hit(res_hit), .res_multi(res_multi), .res_pa(res_pa),
    .walk_req_valid(walk_req_valid), .walk_req_ready(walk_req_ready),
    .walk_req_va(walk_req_va), .walk_req_strand(walk_req_strand),
    .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn), .rf_size(rf_size),
    .rf_strand(rf_strand),
    .inv_all(inv_all), .inv_strand_en(inv_strand_en), .inv_strand(inv_strand)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    done = 0;
  string cur_tag = "R9";

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  // ---------------- reference model ----------------
  bit          m_v   [NE];
  logic [63:0] m_va  [NE];
  logic [63:0] m_pa  [NE];
  int          m_sz  [NE];
  int          m_sid [NE];
  int          m_rr;
  bit          m_pend;
  logic [47:0] m_pva;
  logic [2:0]  m_psid;
  bit          e_rv, e_hit, e_multi;
  logic [39:0] e_pa;

  function automatic int pshift(input int code);
    case (code)
      1: return 16;
      2: return 22;
      3: return 28;
      4: return 31;
      default: return 13;
    endcase
  endfunction

  always @(posedge clk) begin : model
    int cnt, first, s, vic;
    bit acc;
    logic [63:0] a, pa;
    if (!rst_n) begin
      for (int i = 0; i < NE; i++) m_v[i] = 0;
      m_rr = 0; m_pend = 0; m_pva = '0; m_psid = '0;
      e_rv = 0; e_hit = 0; e_multi = 0; e_pa = '0;
    end else begin
      acc = lk_valid && !m_pend;
      a = {16'h0, lk_va};
      cnt = 0; first = -1;
      for (int i = 0; i < NE; i++) begin
        s = pshift(m_sz[i]);
        if (m_v[i] && m_sid[i] == int'(lk_strand) && ((a >> s) == (m_va[i] >> s))) begin
          cnt++;
          if (first < 0) first = i;
        end
      end
      e_rv = acc;
      e_hit = acc && cnt > 0;
      e_multi = acc && cnt > 1;
      e_pa = '0;
      if (e_hit) begin
        s = pshift(m_sz[first]);
        pa = ((m_pa[first] >> s) << s) | (a & ((64'd1 << s) - 64'd1));
        e_pa = pa[39:0];
      end
      if (m_pend && walk_req_ready) m_pend = 0;
      if (acc && cnt == 0) begin
        m_pend = 1; m_pva = lk_va; m_psid = lk_strand;
      end
      if (inv_all) begin
        for (int i = 0; i < NE; i++) m_v[i] = 0;
      end else if (inv_strand_en) begin
        for (int i = 0; i < NE; i++) if (m_sid[i] == int'(inv_strand)) m_v[i] = 0;
      end else if (rf_valid) begin
        vic = -1;
        for (int i = NE - 1; i >= 0; i--) if (!m_v[i]) vic = i;
        if (vic < 0) begin
          vic = m_rr;
          m_rr = (m_rr + 1) % NE;
        end
        m_v[vic] = 1;
        m_va[vic] = {16'h0, rf_vpn, 13'h0};
        m_pa[vic] = {24'h0, rf_ppn, 13'h0};
        m_sz[vic] = int'(rf_size);
        m_sid[vic] = int'(rf_strand);
      end
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(res_valid === e_rv, "R1", "res_valid", 64'(res_valid), 64'(e_rv));
      if (e_rv) begin
        chk(res_hit === e_hit, cur_tag, "res_hit", 64'(res_hit), 64'(e_hit));
        chk(res_multi === e_multi, (cur_tag == "R6") ? "R6" : cur_tag, "res_multi",
            64'(res_multi), 64'(e_multi));
        chk(res_pa === e_pa, cur_tag, "res_pa", 64'(res_pa), 64'(e_pa));
      end
      chk(lk_ready === !m_pend, "R4", "lk_ready", 64'(lk_ready), 64'(!m_pend));
      chk(walk_req_valid === m_pend, "R4", "walk_req_valid", 64'(walk_req_valid), 64'(m_pend));
      if (m_pend) begin
        chk(walk_req_va === m_pva, "R4", "walk_req_va", 64'(walk_req_va), 64'(m_pva));
        chk(walk_req_strand === m_psid, "R4", "walk_req_strand",
            64'(walk_req_strand), 64'(m_psid));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog expired act=%0d exp=<150000", cyc);
      finish_up();
    end
  end

  // ---------------- stimulus ----------------
  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_lookup(input logic [63:0] va, input int sid);
    while (!lk_ready) step();
    lk_valid = 1'b1; lk_va = va[47:0]; lk_strand = 3'(sid);
    step();
    lk_valid = 1'b0;
    step();
    step();
  endtask

  task automatic do_refill(input logic [63:0] va, input logic [63:0] pa,
                           input int sz, input int sid);
    rf_valid = 1'b1; rf_vpn = va[47:13]; rf_ppn = pa[39:13];
    rf_size = 3'(sz); rf_strand = 3'(sid);
    step();
    rf_valid = 1'b0;
  endtask

  task automatic do_inv_strand(input int sid);
    inv_strand_en = 1'b1; inv_strand = 3'(sid);
    step();
    inv_strand_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R9: state right after reset
    chk(lk_ready === 1'b1, "R9", "lk_ready after reset", 64'(lk_ready), 64'd1);
    chk(res_valid === 1'b0, "R9", "res_valid after reset", 64'(res_valid), 64'd0);
    chk(walk_req_valid === 1'b0, "R9", "walk_req_valid after reset", 64'(walk_req_valid), 64'd0);
    do_lookup(64'h0000_1234_7ABC, 0);

    // R2: each size, inside and just past the page
    cur_tag = "R2";
    do_refill(64'h0000_1234_6000, 64'h00_5555_6000, 0, 0);
    do_refill(64'h0000_00AB_0000, 64'h00_0077_0000, 1, 1);
    do_refill(64'h0000_1240_0000, 64'h00_3C12_3000, 2, 2);
    do_refill(64'h0007_0000_0000, 64'h05_3000_0000, 3, 3);
    do_refill(64'h0012_8000_0000, 64'h00_8000_0000, 4, 4);
    do_refill(64'h0000_2000_0000, 64'h11_0000_2000, 6, 0);
    step();
    do_lookup(64'h0000_1234_7ABC, 0);
    do_lookup(64'h0000_1234_8000, 0);
    do_lookup(64'h0000_00AB_FFFC, 1);
    do_lookup(64'h0000_00AC_0000, 1);
    do_lookup(64'h0000_127F_F123, 2);
    do_lookup(64'h0000_1280_0000, 2);
    do_lookup(64'h0007_0ABC_DEF0, 3);
    do_lookup(64'h0007_1000_0000, 3);
    do_lookup(64'h0012_FFFF_FFF8, 4);
    do_lookup(64'h0013_0000_0000, 4);
    do_lookup(64'h0000_2000_1FF0, 0);
    do_lookup(64'h0000_2000_2000, 0);

    // R3: same page, other strand
    cur_tag = "R3";
    do_lookup(64'h0000_1234_7ABC, 5);
    do_lookup(64'h0012_8000_0040, 1);

    // R4: walker stalls, extra lookup offered while pending
    cur_tag = "R4";
    walk_req_ready = 1'b0;
    do_lookup(64'h0000_9999_0000, 7);
    repeat (4) step();
    lk_valid = 1'b1; lk_va = 48'h0000_1234_7ABC; lk_strand = 3'd0;
    step();
    lk_valid = 1'b0;
    step();
    walk_req_ready = 1'b1;
    step();
    step();

    // R6: overlapping entries, lowest index wins
    cur_tag = "R6";
    do_refill(64'h0000_4444_0000, 64'h00_1000_0000, 0, 2);
    do_refill(64'h0000_4444_0000, 64'h00_2000_0000, 1, 2);
    step();
    do_lookup(64'h0000_4444_0010, 2);
    do_lookup(64'h0000_4444_8010, 2);

    // R7: strand invalidate then full invalidate
    cur_tag = "R7";
    do_inv_strand(2);
    step();
    do_lookup(64'h0000_127F_F123, 2);
    do_lookup(64'h0000_4444_0010, 2);
    do_lookup(64'h0000_00AB_FFFC, 1);
    inv_all = 1'b1; step(); inv_all = 1'b0;
    step();
    do_lookup(64'h0000_1234_7ABC, 0);
    do_lookup(64'h0007_0ABC_DEF0, 3);

    // R8: refill colliding with invalidates is dropped
    cur_tag = "R8";
    inv_strand_en = 1'b1; inv_strand = 3'd6;
    do_refill(64'h0000_5000_0000, 64'h00_0500_0000, 0, 0);
    inv_strand_en = 1'b0;
    step();
    do_lookup(64'h0000_5000_0000, 0);
    inv_all = 1'b1;
    do_refill(64'h0000_5100_0000, 64'h00_0510_0000, 0, 0);
    inv_all = 1'b0;
    step();
    do_lookup(64'h0000_5100_0000, 0);

    // R5: fill all entries, then round-robin and first-free placement
    cur_tag = "R5";
    for (int i = 0; i < NE; i++) begin
      do_refill(64'h0010_0000_0000 + 64'(i) * 64'h2000,
                64'h00_0100_0000 + 64'(i) * 64'h2000, 0, (i == 5) ? 3 : 1);
    end
    step();
    do_lookup(64'h0010_0000_0000, 1);
    do_lookup(64'h0010_0000_0000 + 64'd127 * 64'h2000, 1);
    do_lookup(64'h0010_0000_0000 + 64'd5 * 64'h2000, 3);
    do_refill(64'h0020_0000_0000, 64'h00_0AA0_0000, 0, 1);
    step();
    do_lookup(64'h0010_0000_0000, 1);
    do_lookup(64'h0020_0000_0000, 1);
    do_lookup(64'h0010_0000_2000, 1);
    do_refill(64'h0021_0000_0000, 64'h00_0BB0_0000, 0, 1);
    step();
    do_lookup(64'h0010_0000_2000, 1);
    do_inv_strand(3);
    do_refill(64'h0022_0000_0000, 64'h00_0CC0_0000, 0, 1);
    step();
    do_lookup(64'h0022_0000_0000, 1);
    do_lookup(64'h0010_0000_0000 + 64'd5 * 64'h2000, 3);
    do_lookup(64'h0010_0000_4000, 1);
    do_refill(64'h0023_0000_0000, 64'h00_0DD0_0000, 0, 1);
    step();
    do_lookup(64'h0010_0000_4000, 1);
    do_lookup(64'h0010_0000_6000, 1);
    do_lookup(64'h0023_0000_0000, 1);

    repeat (4) step();
    finish_up();
  end

endmodule